// File: doc/BRIEF.md
# Latched Push-Pull PWM Generator

This block generates pulse-width modulation from a free-running period counter and steers successive pulses to two alternating legs, A and B. Each period opens with a short blanking interval. During that interval both legs are off, and the interval also sets the dead time between the two legs. Once blanking ends, the selected leg turns on. It stays on until the counter reaches a duty threshold or a shutdown request arrives.

A termination latch holds the pulse off for the rest of the period, so a period can never produce a second pulse. The threshold is captured only at the start of a period. An external sync pulse restarts the counter, which lets several instances run locked to one master.

A parameter selects the level of an idle leg: low, or high. All pins are plain control and status signals. The block has no streaming interface, so there is no valid/ready handshake or back-pressure.

Top module: `pwm_pushpull`

## Requirements
- R1: The period counter steps 0, 1, ..., PERIOD-1 and then wraps to 0. Without sync, the same leg turns on again exactly 2*PERIOD cycles later.
- R2: While the counter is below BLANK (the blanking interval that starts each period), both outputs sit at the off level.
- R3: With threshold T, the selected leg is on in the cycles where BLANK <= count < T. It turns off in the cycle where the count reaches T.
- R4: A pulse that has ended stays off until the next period starts. This holds even after shutdown is released within the same period.
- R5: While shutdown is 1, both outputs are off in that same cycle, and the pulse stays terminated for the rest of the period.
- R6: The active leg alternates every period. The first period after reset drives leg A (`out_a`).
- R7: With OFF_HIGH=0 an off output is 0 and an on output is 1. With OFF_HIGH=1 both levels are inverted.
- R8: A sync pulse of 1 makes the count 0 in the next cycle. That ends any pulse in progress and starts a new period.
- R9: A threshold at or below BLANK gives no on-cycles. A threshold at or above PERIOD keeps the leg on from count BLANK through PERIOD-1.
- R10: `duty_thr` is sampled only in the count-0 cycle. A change made mid-period takes effect in the following period.
- R11: While rst is 1, both outputs are at the off level. After release the count starts at 0 and the latch starts set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| duty_thr | input | CNT_W | Duty threshold, compared with the period count |
| sync_in | input | 1 | Restarts the period counter |
| shutdown | input | 1 | Immediate pulse termination request |
| out_a | output | 1 | Leg A drive |
| out_b | output | 1 | Leg B drive |

## Verification
The bench drives mid-period threshold changes. A design that compares against the live input would cut the pulse short instead of finishing the period on the old value.

A one-cycle shutdown followed by release catches a latch that re-arms within the period, because such a design emits a second pulse. A sync during a pulse checks that the pulse ends and that the legs keep alternating.

Zero and full thresholds expose off-by-one errors at the blanking edge and the wrap. A second instance with inverted idle polarity exposes polarity applied to the wrong term.

// File: rtl/pwm_pp_pkg.sv
package pwm_pp_pkg;
  typedef enum logic {
    LEG_A = 1'b0,
    LEG_B = 1'b1
  } leg_e;
endpackage

// File: rtl/pwm_period_timer.sv
module pwm_period_timer #(
  parameter int PERIOD = 20,
  parameter int BLANK  = 2,
  parameter int CNT_W  = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sync_in,
  output logic [CNT_W-1:0] cnt,
  output logic             blank,
  output logic             start
);
  localparam logic [CNT_W-1:0] LAST_C  = CNT_W'(PERIOD - 1);
  localparam logic [CNT_W-1:0] BLANK_C = CNT_W'(BLANK);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)                             cnt_q <= '0;
    else if (sync_in || cnt_q == LAST_C) cnt_q <= '0;
    else                                 cnt_q <= cnt_q + 1'b1;
  end

  assign cnt   = cnt_q;
  assign start = (cnt_q == '0);
  assign blank = (cnt_q < BLANK_C);

  assert_cnt_in_range_R1: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= LAST_C);
  assert_wrap_R1: assert property (@(posedge clk) disable iff (rst)
    (cnt_q == LAST_C) |=> (cnt_q == '0));
  assert_sync_restart_R8: assert property (@(posedge clk) disable iff (rst)
    sync_in |=> (cnt_q == '0));
endmodule

// File: rtl/pwm_term_latch.sv
module pwm_term_latch #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             blank,
  input  logic [CNT_W-1:0] cnt,
  input  logic [CNT_W-1:0] duty_thr,
  input  logic             shutdown,
  output logic             pulse_on
);
  logic [CNT_W-1:0] thr_q;
  logic             term_q;
  logic             reached;

  assign reached = !blank && (cnt >= thr_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      term_q <= 1'b1;
      thr_q  <= '0;
    end else begin
      if (start) thr_q <= duty_thr;
      if (shutdown)     term_q <= 1'b1;
      else if (start)   term_q <= 1'b0;
      else if (reached) term_q <= 1'b1;
    end
  end

  assign pulse_on = !blank && !term_q && !reached && !shutdown;

  assert_hold_off_R4: assert property (@(posedge clk) disable iff (rst)
    (term_q && !start) |=> !pulse_on);
  assert_shutdown_latch_R5: assert property (@(posedge clk) disable iff (rst)
    shutdown |=> !pulse_on);
  assert_thr_stable_R10: assert property (@(posedge clk) disable iff (rst)
    !start |=> $stable(thr_q));
endmodule

// File: rtl/pwm_steer.sv
module pwm_steer
  import pwm_pp_pkg::*;
#(
  parameter bit OFF_HIGH = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic pulse_on,
  output logic out_a,
  output logic out_b
);
  leg_e sel_q;

  always_ff @(posedge clk) begin
    if (rst)        sel_q <= LEG_B;
    else if (start) sel_q <= (sel_q == LEG_A) ? LEG_B : LEG_A;
  end

  assign out_a = (pulse_on && sel_q == LEG_A) ^ OFF_HIGH;
  assign out_b = (pulse_on && sel_q == LEG_B) ^ OFF_HIGH;

  assert_toggle_R6: assert property (@(posedge clk) disable iff (rst)
    start |=> (sel_q != $past(sel_q)));
endmodule

// File: rtl/pwm_pushpull.sv
module pwm_pushpull #(
  parameter int PERIOD   = 20,
  parameter int BLANK    = 2,
  parameter int CNT_W    = 8,
  parameter bit OFF_HIGH = 1'b0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] duty_thr,
  input  logic             sync_in,
  input  logic             shutdown,
  output logic             out_a,
  output logic             out_b
);
  localparam logic OFF_LVL = OFF_HIGH;

  logic [CNT_W-1:0] cnt;
  logic             blank;
  logic             start;
  logic             pulse_on;

  pwm_period_timer #(.PERIOD(PERIOD), .BLANK(BLANK), .CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst(rst), .sync_in(sync_in),
    .cnt(cnt), .blank(blank), .start(start)
  );

  pwm_term_latch #(.CNT_W(CNT_W)) u_latch (
    .clk(clk), .rst(rst), .start(start), .blank(blank), .cnt(cnt),
    .duty_thr(duty_thr), .shutdown(shutdown), .pulse_on(pulse_on)
  );

  pwm_steer #(.OFF_HIGH(OFF_HIGH)) u_steer (
    .clk(clk), .rst(rst), .start(start), .pulse_on(pulse_on),
    .out_a(out_a), .out_b(out_b)
  );

  assert_blank_off_R2: assert property (@(posedge clk) disable iff (rst)
    blank |-> (out_a == OFF_LVL && out_b == OFF_LVL));
  assert_not_both_on_R6: assert property (@(posedge clk) disable iff (rst)
    !(out_a != OFF_LVL && out_b != OFF_LVL));
endmodule

// File: tb/tb_pwm_pushpull.sv
module tb_pwm_pushpull;
  localparam int PERIOD = 20;
  localparam int BLANK  = 2;
  localparam int CNT_W  = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [CNT_W-1:0] duty_thr = 8'd10;
  logic sync_in = 1'b0;
  logic shutdown = 1'b0;
  logic out_a, out_b, hi_a, hi_b;

  int compared = 0;
  int mismatched = 0;
  bit finished = 1'b0;
  string cur_tag = "R3";

  // behavioural reference state
  int m_cnt = 0, m_thr = 0, m_leg = 1, m_done = 1;

  always #5 clk = ~clk;

  pwm_pushpull #(.PERIOD(PERIOD), .BLANK(BLANK), .CNT_W(CNT_W), .OFF_HIGH(1'b0)) dut (
    .clk(clk), .rst(rst), .duty_thr(duty_thr), .sync_in(sync_in),
    .shutdown(shutdown), .out_a(out_a), .out_b(out_b));

  pwm_pushpull #(.PERIOD(PERIOD), .BLANK(BLANK), .CNT_W(CNT_W), .OFF_HIGH(1'b1)) dut_hi (
    .clk(clk), .rst(rst), .duty_thr(duty_thr), .sync_in(sync_in),
    .shutdown(shutdown), .out_a(hi_a), .out_b(hi_b));

  task automatic chk(input string tag, input logic [1:0] act, input logic [1:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%b expected=%b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic chk_int(input string tag, input int act, input int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    if (rst) begin
      m_cnt = 0; m_thr = 0; m_leg = 1; m_done = 1;
    end else begin
      int period_start;
      period_start = (m_cnt == 0);
      if (shutdown)                              m_done = 1;
      else if (period_start)                     m_done = 0;
      else if (m_cnt >= BLANK && m_cnt >= m_thr) m_done = 1;
      if (period_start) begin
        m_thr = int'(duty_thr);
        m_leg = 1 - m_leg;
      end
      if (sync_in || m_cnt == PERIOD - 1) m_cnt = 0;
      else m_cnt = m_cnt + 1;
    end
  end

  always @(negedge clk) begin
    if (!rst && !finished) begin
      logic on;
      logic [1:0] exp;
      string tag;
      on  = (m_cnt >= BLANK) && !m_done && (m_cnt < m_thr) && !shutdown;
      exp = {on && m_leg == 0, on && m_leg == 1};
      if (m_cnt < BLANK) tag = "R2";
      else if (shutdown) tag = "R5";
      else tag = cur_tag;
      chk(tag, {out_a, out_b}, exp);
      chk("R7", {hi_a, hi_b}, ~exp);
    end
  end

  task automatic at_cnt(input int k);
    do begin @(posedge clk); #2; end while (m_cnt != k);
  endtask

  task automatic count_on(input int n, output int a, output int b);
    a = 0; b = 0;
    repeat (n) begin
      @(negedge clk);
      a += int'(out_a);
      b += int'(out_b);
    end
  endtask

  task automatic summary;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
  endtask

  initial begin
    #(200000 * 10);
    if (!finished) begin
      finished = 1'b1;
      mismatched++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    int a, b, t0, t1;
    logic prev;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R11", {out_a, out_b}, 2'b00);
    chk("R7", {hi_a, hi_b}, 2'b11);
    @(posedge clk); #2;
    rst = 1'b0;

    // R6 / R3: first period drives A for count 2..9, the next drives B
    count_on(PERIOD, a, b);
    chk_int("R6 first period leg A count", a, 8);
    chk_int("R6 first period leg B idle", b, 0);
    count_on(PERIOD, a, b);
    chk_int("R3 second period leg B count", b, 8);
    chk_int("R6 second period leg A idle", a, 0);

    // R1: rising edges of A are 2*PERIOD apart
    prev = out_a; t0 = -1; t1 = -1;
    for (int i = 0; i < 6 * PERIOD && t1 < 0; i++) begin
      @(negedge clk);
      if (out_a && !prev) begin
        if (t0 < 0) t0 = i; else t1 = i;
      end
      prev = out_a;
    end
    chk_int("R1 leg repeat interval", t1 - t0, 2 * PERIOD);

    // R9: zero and full thresholds
    cur_tag = "R9";
    duty_thr = 8'd0;
    repeat (2 * PERIOD) @(posedge clk);
    count_on(2 * PERIOD, a, b);
    chk_int("R9 zero duty", a + b, 0);
    duty_thr = 8'd255;
    repeat (2 * PERIOD) @(posedge clk);
    count_on(2 * PERIOD, a, b);
    chk_int("R9 full duty leg A", a, PERIOD - BLANK);
    chk_int("R9 full duty leg B", b, PERIOD - BLANK);

    // R10: threshold change mid-period waits for the next period
    cur_tag = "R10";
    duty_thr = 8'd10;
    repeat (2 * PERIOD) @(posedge clk);
    at_cnt(5);
    duty_thr = 8'd3;
    count_on(PERIOD - 5, a, b);
    chk_int("R10 old threshold kept", a + b, 5);
    count_on(PERIOD, a, b);
    chk_int("R10 new threshold used", a + b, 1);

    // R5 / R4: one-cycle shutdown mid-pulse, then release
    cur_tag = "R4";
    duty_thr = 8'd15;
    repeat (2 * PERIOD) @(posedge clk);
    at_cnt(6);
    shutdown = 1'b1;
    @(negedge clk);
    chk("R5 same-cycle off", {out_a, out_b}, 2'b00);
    @(posedge clk); #2;
    shutdown = 1'b0;
    count_on(PERIOD - 7, a, b);
    chk_int("R4 stays off after release", a + b, 0);
    count_on(PERIOD, a, b);
    chk_int("R4 next period recovers", a + b, 13);

    // R8: sync in the middle of a pulse
    cur_tag = "R8";
    at_cnt(7);
    sync_in = 1'b1;
    @(posedge clk); #2;
    sync_in = 1'b0;
    count_on(PERIOD, a, b);
    chk_int("R8 restarted period on-cycles", a + b, 13);
    chk_int("R8 single leg per period", (a == 0 || b == 0) ? 1 : 0, 1);

    repeat (2) @(posedge clk);
    finished = 1'b1;
    summary();
    $finish;
  end
endmodule